// File: doc/BRIEF.md
# Sideband GPIO Forwarding Bridge

This block moves general-purpose pin levels across a serial link pair in both directions. On the transmit side, four asynchronous forward inputs are synchronized and sampled once per clock. The link stage carries them to four forward outputs on the receive side. In the opposite direction, four bidirectional pins on the receive side are synchronized and sampled. The samples travel back to the transmit side as slow snapshots on a one-bit back channel. There they may drive four transmit-side outputs.

Each configurable pin has a two-bit mode. The modes are: input/forward, output from the remote side, output from a local register bit, and off. The forward path updates on every clock. A back-channel snapshot goes out only when a programmable frame timer expires, so the reverse path runs far slower than the forward path. Taking the power-down input low clears every register to its default value, including the remote latch and the timer. The serializer and the back-channel modem are modelled as plain bit streams. The back-channel line is brought out as a port so that the link can be observed.

Sender states: SND_IDLE (the timer counts down), SND_START (the start bit), SND_DATA (one cycle per pin bit) and SND_STOP (the stop bit). The sender moves SND_IDLE→SND_START when the timer reaches zero, and SND_START→SND_DATA. It moves SND_DATA→SND_STOP after the last pin bit, and SND_STOP→SND_IDLE. Receiver states: RCV_IDLE (waiting for a low line), RCV_DATA (collecting pin bits) and RCV_STOP (checking the stop bit). The receiver moves RCV_IDLE→RCV_DATA on a low line, and RCV_DATA→RCV_STOP after the last bit. It moves RCV_STOP→RCV_IDLE and latches the snapshot only if the line is high.

Top module: `gpio_bridge`

## Requirements
- R1: While pd_n is low and on the first cycle after its release, fwd_out, tx_gpo, rx_pin_out and rx_pin_oe are all zero.
- R2: fwd_out[i] equals the level of fwd_in[i] sampled three rising clock edges earlier: two synchronizer flops plus the link stage.
- R3: For tx_gpo pin i, the mode field is cfg 0 bits [2i+1:2i]. Mode 2'b10 drives the local register bit i, held in address 1 bits [3:0]. Modes 2'b00 and 2'b11 drive 0. The level appears on the clock edge that completes the write.
- R4: In mode 2'b01, tx_gpo[i] shows bit i of the last back-channel snapshot received. It keeps that value, whatever the receive-side pins do, until the next frame arrives.
- R5: A snapshot carries the synchronized rx_pin_in level for each pin in mode 2'b00. Each other pin contributes 0. The receive-side mode fields sit in address 2 with the same bit layout as address 0.
- R6: The back-channel frame on bc_line is one low start bit, then four data bits with pin 0 first, then one high stop bit. The line idles high. Consecutive start bits are exactly D+7 cycles apart, where D is the divider in address 4 bits [7:0].
- R7: For rx pin i, mode 2'b01 sets rx_pin_oe[i] and drives fwd_out[i]. Mode 2'b10 sets rx_pin_oe[i] and drives the local bit, held in address 3 bits [3:0]. Modes 2'b00 and 2'b11 clear rx_pin_oe[i] and drive 0.
- R8: Writes to addresses 5 to 7 change no register and no output.
- R9: A power-down pulse returns every register to its default value, including configuration written earlier. The modes go to 2'b00, the local bits to 0, the divider to 15 (a 22-cycle frame spacing) and the remote latch to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| pd_n | input | 1 | Active-low power-down; clears all state |
| fwd_in | input | 4 | Asynchronous transmit-side forward inputs |
| fwd_out | output | 4 | Receive-side forward outputs |
| tx_gpo | output | 4 | Transmit-side configurable outputs |
| rx_pin_in | input | 4 | Asynchronous level of the receive-side bidirectional pins |
| rx_pin_out | output | 4 | Value driven on the receive-side pins |
| rx_pin_oe | output | 4 | Output enable for the receive-side pins |
| bc_line | output | 1 | Back-channel bit stream |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |

## Verification
The forward outputs are due on the third rising edge after a change of fwd_in. The table loop samples one cycle before that edge, where the old value must still be present, and again just after it. A register write reaches tx_gpo and rx_pin_oe on the edge that takes it, so those outputs are read at the falling edge that ends the write. Back-channel results are due within D+7 cycles plus synchronizer delay. Those checks poll with a bound a little above that figure, and they read tx_gpo across a window shorter than one frame spacing to show that the value holds between frames.

// File: rtl/gpio_bridge_pkg.sv
package gpio_bridge_pkg;

    typedef enum logic [1:0] {
        PM_INPUT  = 2'b00,
        PM_REMOTE = 2'b01,
        PM_LOCAL  = 2'b10,
        PM_OFF    = 2'b11
    } pin_mode_e;

    typedef enum logic [1:0] {
        SND_IDLE,
        SND_START,
        SND_DATA,
        SND_STOP
    } snd_state_e;

    typedef enum logic [1:0] {
        RCV_IDLE,
        RCV_DATA,
        RCV_STOP
    } rcv_state_e;

    localparam logic [2:0] A_TX_MODE  = 3'd0;
    localparam logic [2:0] A_TX_LOCAL = 3'd1;
    localparam logic [2:0] A_RX_MODE  = 3'd2;
    localparam logic [2:0] A_RX_LOCAL = 3'd3;
    localparam logic [2:0] A_DIVIDER  = 3'd4;

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         pd_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/gpio_bridge_regs.sv
module gpio_bridge_regs
    import gpio_bridge_pkg::*;
#(
    parameter int NPIN      = 4,
    parameter int DIV_W     = 8,
    parameter int CFG_W     = 8,
    parameter int DIV_RESET = 15
) (
    input  logic                clk,
    input  logic                pd_n,
    input  logic                we,
    input  logic [2:0]          addr,
    input  logic [CFG_W-1:0]    wdata,
    output logic [2*NPIN-1:0]   tx_mode,
    output logic [NPIN-1:0]     tx_local,
    output logic [2*NPIN-1:0]   rx_mode,
    output logic [NPIN-1:0]     rx_local,
    output logic [DIV_W-1:0]    divider
);
    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            tx_mode  <= '0;
            tx_local <= '0;
            rx_mode  <= '0;
            rx_local <= '0;
            divider  <= DIV_W'(DIV_RESET);
        end else if (we) begin
            case (addr)
                A_TX_MODE:  tx_mode  <= wdata[2*NPIN-1:0];
                A_TX_LOCAL: tx_local <= wdata[NPIN-1:0];
                A_RX_MODE:  rx_mode  <= wdata[2*NPIN-1:0];
                A_RX_LOCAL: rx_local <= wdata[NPIN-1:0];
                A_DIVIDER:  divider  <= wdata[DIV_W-1:0];
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bc_sender.sv
module gpio_bc_sender
    import gpio_bridge_pkg::*;
#(
    parameter int NPIN      = 4,
    parameter int DIV_W     = 8,
    parameter int DIV_RESET = 15
) (
    input  logic             clk,
    input  logic             pd_n,
    input  logic [DIV_W-1:0] divider,
    input  logic [NPIN-1:0]  snap_in,
    output logic             line,
    output logic             frame_start,
    output logic [NPIN-1:0]  snap_bits
);
    localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIN - 1);

    snd_state_e       state, state_nx;
    logic [DIV_W-1:0] timer;
    logic [IDX_W-1:0] idx;

    assign frame_start = (state == SND_IDLE) && (timer == '0);

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) state <= SND_IDLE;
        else       state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            SND_IDLE:  if (timer == '0) state_nx = SND_START;
            SND_START: state_nx = SND_DATA;
            SND_DATA:  if (idx == LAST) state_nx = SND_STOP;
            SND_STOP:  state_nx = SND_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            timer     <= DIV_W'(DIV_RESET);
            idx       <= '0;
            snap_bits <= '0;
        end else begin
            unique case (state)
                SND_IDLE: begin
                    if (timer == '0) begin
                        timer     <= divider;
                        snap_bits <= snap_in;
                    end else begin
                        timer <= timer - DIV_W'(1);
                    end
                end
                SND_START: idx <= '0;
                SND_DATA:  idx <= idx + IDX_W'(1);
                SND_STOP:  ;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            SND_IDLE:  line = 1'b1;
            SND_START: line = 1'b0;
            SND_DATA:  line = snap_bits[idx];
            SND_STOP:  line = 1'b1;
        endcase
    end
endmodule

// File: rtl/gpio_bc_receiver.sv
module gpio_bc_receiver
    import gpio_bridge_pkg::*;
#(
    parameter int NPIN = 4
) (
    input  logic            clk,
    input  logic            pd_n,
    input  logic            line,
    output logic [NPIN-1:0] rem_bits,
    output logic            rem_valid
);
    localparam int IDX_W = (NPIN > 1) ? $clog2(NPIN) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NPIN - 1);

    rcv_state_e       state, state_nx;
    logic [IDX_W-1:0] idx;
    logic [NPIN-1:0]  shreg;

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) state <= RCV_IDLE;
        else       state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            RCV_IDLE: if (!line) state_nx = RCV_DATA;
            RCV_DATA: if (idx == LAST) state_nx = RCV_STOP;
            RCV_STOP: state_nx = RCV_IDLE;
            default:  state_nx = RCV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            idx       <= '0;
            shreg     <= '0;
            rem_bits  <= '0;
            rem_valid <= 1'b0;
        end else begin
            rem_valid <= 1'b0;
            case (state)
                RCV_IDLE: idx <= '0;
                RCV_DATA: begin
                    shreg[idx] <= line;
                    idx        <= idx + IDX_W'(1);
                end
                RCV_STOP: begin
                    if (line) begin
                        rem_bits  <= shreg;
                        rem_valid <= 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_bridge.sv
module gpio_bridge
    import gpio_bridge_pkg::*;
#(
    parameter int NPIN      = 4,
    parameter int DIV_W     = 8,
    parameter int CFG_W     = 8,
    parameter int DIV_RESET = 15
) (
    input  logic             clk,
    input  logic             pd_n,
    input  logic [NPIN-1:0]  fwd_in,
    output logic [NPIN-1:0]  fwd_out,
    output logic [NPIN-1:0]  tx_gpo,
    input  logic [NPIN-1:0]  rx_pin_in,
    output logic [NPIN-1:0]  rx_pin_out,
    output logic [NPIN-1:0]  rx_pin_oe,
    output logic             bc_line,
    input  logic             cfg_we,
    input  logic [2:0]       cfg_addr,
    input  logic [CFG_W-1:0] cfg_wdata
);
    logic [2*NPIN-1:0] tx_mode, rx_mode;
    logic [NPIN-1:0]   tx_local, rx_local;
    logic [DIV_W-1:0]  divider;
    logic [NPIN-1:0]   fwd_sync, rx_sync, snap_in, snap_bits, rem_bits;
    logic              frame_start, rem_valid;

    gpio_bridge_regs #(
        .NPIN(NPIN), .DIV_W(DIV_W), .CFG_W(CFG_W), .DIV_RESET(DIV_RESET)
    ) u_regs (
        .clk(clk), .pd_n(pd_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .tx_mode(tx_mode), .tx_local(tx_local), .rx_mode(rx_mode),
        .rx_local(rx_local), .divider(divider)
    );

    gpio_sync2 #(.W(NPIN)) u_fwd_sync (.clk(clk), .pd_n(pd_n), .d(fwd_in),    .q(fwd_sync));
    gpio_sync2 #(.W(NPIN)) u_rx_sync  (.clk(clk), .pd_n(pd_n), .d(rx_pin_in), .q(rx_sync));

    // link stage: the forward frame as recovered on the receive side
    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) fwd_out <= '0;
        else       fwd_out <= fwd_sync;
    end

    gpio_bc_sender #(.NPIN(NPIN), .DIV_W(DIV_W), .DIV_RESET(DIV_RESET)) u_snd (
        .clk(clk), .pd_n(pd_n), .divider(divider), .snap_in(snap_in),
        .line(bc_line), .frame_start(frame_start), .snap_bits(snap_bits)
    );

    gpio_bc_receiver #(.NPIN(NPIN)) u_rcv (
        .clk(clk), .pd_n(pd_n), .line(bc_line),
        .rem_bits(rem_bits), .rem_valid(rem_valid)
    );

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        pin_mode_e tm, rm;
        assign tm = pin_mode_e'(tx_mode[2*i +: 2]);
        assign rm = pin_mode_e'(rx_mode[2*i +: 2]);

        always_comb begin
            unique case (tm)
                PM_REMOTE: tx_gpo[i] = rem_bits[i];
                PM_LOCAL:  tx_gpo[i] = tx_local[i];
                default:   tx_gpo[i] = 1'b0;
            endcase
            unique case (rm)
                PM_REMOTE: begin rx_pin_oe[i] = 1'b1; rx_pin_out[i] = fwd_out[i];  end
                PM_LOCAL:  begin rx_pin_oe[i] = 1'b1; rx_pin_out[i] = rx_local[i]; end
                default:   begin rx_pin_oe[i] = 1'b0; rx_pin_out[i] = 1'b0;        end
            endcase
            snap_in[i] = (rm == PM_INPUT) ? rx_sync[i] : 1'b0;
        end
    end
endmodule

// File: rtl/gpio_bridge_chk.sv
module gpio_bridge_chk #(
    parameter int NPIN = 4
) (
    input logic              clk,
    input logic              pd_n,
    input logic [NPIN-1:0]   fwd_in,
    input logic [NPIN-1:0]   fwd_out,
    input logic [NPIN-1:0]   rx_pin_out,
    input logic [NPIN-1:0]   rx_pin_oe,
    input logic [NPIN-1:0]   rem_bits,
    input logic              rem_valid,
    input logic              frame_start,
    input logic [NPIN-1:0]   snap_bits,
    input logic [2*NPIN-1:0] rx_mode
);
    logic [1:0]      run_cnt;
    logic [7:0]      gap;
    logic [NPIN-1:0] in_mask;

    for (genvar i = 0; i < NPIN; i++) begin : g_mask
        assign in_mask[i] = (rx_mode[2*i +: 2] == 2'b00);
    end

    always_ff @(posedge clk or negedge pd_n) begin
        if (!pd_n) begin
            run_cnt <= '0;
            gap     <= '1;
        end else begin
            if (run_cnt != 2'd3) run_cnt <= run_cnt + 2'd1;
            if (frame_start)     gap <= '0;
            else if (gap != '1)  gap <= gap + 8'd1;
        end
    end

    p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!pd_n)
        $rose(pd_n) |-> (fwd_out == '0 && rx_pin_oe == '0 && rem_bits == '0));

    p_fwd_latency_r2: assert property (@(posedge clk) disable iff (!pd_n)
        (run_cnt == 2'd3) |-> (fwd_out == $past(fwd_in, 3)));

    p_remote_hold_r4: assert property (@(posedge clk) disable iff (!pd_n)
        !rem_valid |-> $stable(rem_bits));

    p_snap_mask_r5: assert property (@(posedge clk) disable iff (!pd_n)
        frame_start |=> ((snap_bits & ~$past(in_mask)) == '0));

    p_frame_gap_r6: assert property (@(posedge clk) disable iff (!pd_n)
        frame_start |-> (gap >= 8'(NPIN + 2)));

    p_oe_gate_r7: assert property (@(posedge clk) disable iff (!pd_n)
        ((rx_pin_out & ~rx_pin_oe) == '0));
endmodule

bind gpio_bridge gpio_bridge_chk #(.NPIN(NPIN)) u_chk (
    .clk(clk), .pd_n(pd_n), .fwd_in(fwd_in), .fwd_out(fwd_out),
    .rx_pin_out(rx_pin_out), .rx_pin_oe(rx_pin_oe), .rem_bits(rem_bits),
    .rem_valid(rem_valid), .frame_start(frame_start), .snap_bits(snap_bits),
    .rx_mode(rx_mode)
);

// File: tb/gpio_bridge_tb_top.sv
module gpio_bridge_tb_top;
    logic       clk = 1'b0;
    logic       pd_n = 1'b0;
    logic [3:0] fwd_in = '0, rx_pin_in = '0;
    logic [3:0] fwd_out, tx_gpo, rx_pin_out, rx_pin_oe;
    logic       bc_line;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;

    int applied = 0;
    int miscompares = 0;

    // stimulus nibble, expected fwd_out nibble
    localparam logic [7:0] VEC [8] = '{8'h11, 8'h22, 8'h44, 8'h88,
                                       8'hFF, 8'h00, 8'hAA, 8'h55};

    always #5 clk = ~clk;

    gpio_bridge dut_i (
        .clk(clk), .pd_n(pd_n), .fwd_in(fwd_in), .fwd_out(fwd_out),
        .tx_gpo(tx_gpo), .rx_pin_in(rx_pin_in), .rx_pin_out(rx_pin_out),
        .rx_pin_oe(rx_pin_oe), .bc_line(bc_line), .cfg_we(cfg_we),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        applied++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic wait_gpo(input string req, input logic [3:0] exp, input int lim);
        for (int n = 0; n < lim && tx_gpo !== exp; n++) @(negedge clk);
        check(req, {4'h0, tx_gpo}, {4'h0, exp});
    endtask

    task automatic fall_gap(output int n);
        logic prev;
        n = 0;
        prev = bc_line;
        while (1) begin
            @(negedge clk);
            n++;
            if (prev && !bc_line) break;
            prev = bc_line;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end

    initial begin
        int g;
        logic [3:0] prev_exp;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 fwd_out in power-down", {4'h0, fwd_out}, 8'h00);
        pd_n = 1'b1;
        @(negedge clk);
        check("R1 fwd_out", {4'h0, fwd_out}, 8'h00);
        check("R1 tx_gpo", {4'h0, tx_gpo}, 8'h00);
        check("R1 rx_pin_oe", {4'h0, rx_pin_oe}, 8'h00);
        check("R1 rx_pin_out", {4'h0, rx_pin_out}, 8'h00);

        // R2: forward path vectors
        prev_exp = 4'h0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            fwd_in = VEC[i][7:4];
            repeat (2) @(posedge clk);
            @(negedge clk);
            check("R2 not yet", {4'h0, fwd_out}, {4'h0, prev_exp});
            @(posedge clk);
            @(negedge clk);
            check("R2 forwarded", {4'h0, fwd_out}, {4'h0, VEC[i][3:0]});
            prev_exp = VEC[i][3:0];
        end
        fwd_in = 4'h0;

        // R3 / R8: local and off modes on tx_gpo
        wr(3'd0, 8'hAA);
        wr(3'd1, 8'hF5);
        check("R3 local drive", {4'h0, tx_gpo}, 8'h05);
        wr(3'd7, 8'hFF);
        wr(3'd5, 8'h00);
        check("R8 unused address", {4'h0, tx_gpo}, 8'h05);
        wr(3'd1, 8'h0F);
        wr(3'd0, 8'b10_00_11_10);
        check("R3 mixed modes", {4'h0, tx_gpo}, 8'h09);
        wr(3'd0, 8'hFF);
        check("R3 off mode", {4'h0, tx_gpo}, 8'h00);
        wr(3'd0, 8'h00);
        check("R3 input mode", {4'h0, tx_gpo}, 8'h00);

        // R6: frame spacing at the default divider, then at 10
        fall_gap(g);
        fall_gap(g);
        check("R6 default spacing", 8'(g), 8'd22);
        wr(3'd4, 8'd10);
        fall_gap(g); fall_gap(g); fall_gap(g);
        check("R6 divider 10 spacing", 8'(g), 8'd17);

        // R4: remote mode and hold between frames
        wr(3'd0, 8'h55);
        rx_pin_in = 4'b1010;
        wait_gpo("R4 remote arrives", 4'b1010, 100);
        wr(3'd4, 8'd200);
        repeat (40) @(negedge clk);
        rx_pin_in = 4'b0101;
        repeat (120) @(negedge clk);
        check("R4 hold until frame", {4'h0, tx_gpo}, 8'h0A);
        wait_gpo("R4 remote update", 4'b0101, 300);
        wr(3'd4, 8'd10);

        // R5: non-input pins are masked from the snapshot
        wr(3'd2, 8'h08);
        rx_pin_in = 4'b1111;
        check("R7 local oe", {4'h0, rx_pin_oe}, 8'h02);
        wait_gpo("R5 masked snapshot", 4'b1101, 400);

        // R7: receive-side pin modes
        wr(3'd2, 8'hC9);
        wr(3'd3, 8'h02);
        @(negedge clk);
        fwd_in = 4'b0001;
        repeat (4) @(negedge clk);
        check("R7 oe", {4'h0, rx_pin_oe}, 8'h03);
        check("R7 out fwd=1", {4'h0, rx_pin_out}, 8'h03);
        fwd_in = 4'b0000;
        repeat (4) @(negedge clk);
        check("R7 out fwd=0", {4'h0, rx_pin_out}, 8'h02);
        wait_gpo("R5 single input pin", 4'b0100, 100);

        // R9: power-down restores defaults
        @(negedge clk);
        pd_n = 1'b0;
        repeat (2) @(negedge clk);
        pd_n = 1'b1;
        @(negedge clk);
        check("R9 tx_gpo default", {4'h0, tx_gpo}, 8'h00);
        check("R9 oe default", {4'h0, rx_pin_oe}, 8'h00);
        wr(3'd0, 8'h55);
        check("R9 remote latch cleared", {4'h0, tx_gpo}, 8'h00);
        fall_gap(g);
        fall_gap(g);
        check("R9 divider default", 8'(g), 8'd22);
        wait_gpo("R9 remote after reset", 4'b1111, 100);

        $display("== %0d vectors applied, %0d miscompares ==", applied, miscompares);
        $finish;
    end
endmodule